// File: doc/BRIEF.md
# Burst Column Order Generator

This block turns a burst request into the sequence of low column offsets that a double-data-rate memory visits during one burst. A request carries the three low bits of the starting column, a three-bit burst-length code and an ordering bit. Once a request is accepted, the block produces one offset per clock, marks the final one, and then goes idle. The same mode-bit encodings are used for length and ordering as the memory's own mode register, so a controller can feed those bits to the block unchanged.

Two orderings are supported. Interleaved ordering XORs the start column with the beat number. Sequential ordering wraps within a group of four columns. For eight-beat bursts, sequential ordering first walks the four-column nibble that holds the start column. It then walks the other nibble, starting from the same two low bits. It never wraps linearly through all eight columns.

A request that arrives while a burst is running is dropped, unless it arrives on the final beat. In that case the next burst follows with no gap. A reserved length code produces an error pulse and no beats.

Top module: `burst_order_gen`

## Requirements
- R1: The length code `3'b010` gives a burst of 4 beats and `3'b011` gives a burst of 8 beats. Every other code is reserved.
- R2: The ordering bit selects the order: 0 means sequential and 1 means interleaved.
- R3: In a sequential 4-beat burst with start column s, beat i has offset bits [1:0] = (s+i) mod 4 and offset bit 2 = s[2].
- R4: In a sequential 8-beat burst, beats 0..3 stay in the nibble of s (bit 2 = s[2]) and beats 4..7 lie in the other nibble. In both halves, bits [1:0] = (s+i) mod 4. For example, start 5 gives 5,6,7,4,1,2,3,0.
- R5: In an interleaved burst, beat i has offset s XOR i, for i from 0 to N-1.
- R6: The first beat is valid one clock after the accepted start is sampled. The following beats come on consecutive clocks, one per clock.
- R7: `last_o` is high only together with the final beat of a burst: beat 3 for length 4 and beat 7 for length 8.
- R8: A start sampled during a beat that is not the final one is ignored. The running burst keeps its offsets and its length.
- R9: A start sampled on the final beat is accepted, and its beat 0 appears on the very next clock.
- R10: An accepted start with a reserved length code raises `cfg_err_o` for one clock, one clock after the start is sampled, and produces no beats.
- R11: While reset is asserted and right after it, `beat_vld_o`, `last_o` and `cfg_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Burst request strobe |
| start_col_i | input | 3 | Low bits of the starting column |
| len_code_i | input | 3 | Burst-length code |
| order_i | input | 1 | Ordering bit (0 sequential, 1 interleaved) |
| beat_vld_o | output | 1 | A beat offset is valid |
| col_off_o | output | 3 | Column offset of the current beat |
| last_o | output | 1 | Final beat of the burst |
| cfg_err_o | output | 1 | Reserved length code on an accepted start |

## Verification
Every result is due exactly one clock after the start edge that causes it. That edge produces either beat 0 or the error pulse, and each later beat follows on one further clock. The bench drives its inputs on the falling edge. On each rising edge it advances a queue-based reference model that takes in the same sampled inputs. On the next falling edge it compares valid, offset, last and error against the head of that queue. This keeps every comparison exactly one register stage behind the stimulus. Back-to-back requests are issued exactly N clocks after the previous start so that they land on the final beat. Requests in the middle of a burst are issued with different fields, so that acting on one would show up as a changed offset.

// File: rtl/burst_order_pkg.sv
// Package: shared encodings for the burst column order generator.
// Assumes the length and order fields use the memory's mode-bit encodings.
package burst_order_pkg;
    localparam int COL_W  = 3;
    localparam int CODE_W = 3;
    localparam int BEAT_W = COL_W;
    localparam logic [CODE_W-1:0] LEN_CODE_4 = 3'b010;
    localparam logic [CODE_W-1:0] LEN_CODE_8 = 3'b011;

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } order_e;
endpackage

// File: rtl/burst_cfg_decode.sv
// Module: burst_cfg_decode
// Decodes the burst-length code into a legal flag and an eight-beat flag.
// Assumes only the two legal codes from the package; everything else is reserved.
module burst_cfg_decode
    import burst_order_pkg::*;
(
    input  logic [CODE_W-1:0] len_code_i,
    output logic              len_ok_o,
    output logic              is8_o
);
    // Purpose: classify the code as 4-beat, 8-beat or reserved.
    always_comb begin
        len_ok_o = 1'b0;
        is8_o    = 1'b0;
        case (len_code_i)
            LEN_CODE_4: len_ok_o = 1'b1;
            LEN_CODE_8: begin
                len_ok_o = 1'b1;
                is8_o    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/burst_beat_seq.sv
// Module: burst_beat_seq
// Counts the beats of one burst, flags the final beat and decides whether a
// start is accepted. A start is taken when idle or on the final beat.
// Assumes len_ok_i and is8_i are decoded from the same cycle's request.
module burst_beat_seq
    import burst_order_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              len_ok_i,
    input  logic              is8_i,
    output logic              active_o,
    output logic [BEAT_W-1:0] beat_o,
    output logic              last_o,
    output logic              load_o,
    output logic              err_o
);
    localparam logic [BEAT_W-1:0] FINAL_4 = BEAT_W'(3);
    localparam logic [BEAT_W-1:0] FINAL_8 = BEAT_W'(7);

    logic is8_q;
    logic accept;

    // Purpose: flag the final beat of the running burst.
    always_comb begin
        last_o = active_o && (beat_o == (is8_q ? FINAL_8 : FINAL_4));
    end

    assign accept = start_i && (!active_o || last_o);
    assign load_o = accept && len_ok_i;

    // Purpose: start, advance and end bursts; register the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            beat_o   <= '0;
            is8_q    <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            err_o <= accept && !len_ok_i;
            if (load_o) begin
                active_o <= 1'b1;
                beat_o   <= '0;
                is8_q    <= is8_i;
            end else if (last_o) begin
                active_o <= 1'b0;
                beat_o   <= '0;
            end else if (active_o) begin
                beat_o <= beat_o + 1'b1;
            end
        end
    end

    AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !active_o); // R10

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !last_o) |=> (active_o && beat_o == BEAT_W'($past(beat_o) + 1'b1))); // R6

    AST_FINAL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !is8_q) |-> (beat_o <= FINAL_4)); // R1
endmodule

// File: rtl/burst_offset_map.sv
// Module: burst_offset_map
// Maps the start column, beat number and ordering to a column offset.
// Assumes beat_i stays below 4 for four-beat bursts, which keeps bit 2 fixed.
module burst_offset_map
    import burst_order_pkg::*;
(
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  order_e            order_i,
    output logic [COL_W-1:0]  col_off_o
);
    localparam int NIB_W = COL_W - 1;

    logic [NIB_W-1:0] wrap_low;

    // Purpose: sequential wrap inside a nibble; the nibble flips after beat 3.
    always_comb begin
        wrap_low = start_col_i[NIB_W-1:0] + beat_i[NIB_W-1:0];
        if (order_i == ORD_INTLV)
            col_off_o = start_col_i ^ beat_i;
        else
            col_off_o = {start_col_i[COL_W-1] ^ beat_i[COL_W-1], wrap_low};
    end
endmodule

// File: rtl/burst_order_gen.sv
// Module: burst_order_gen (top)
// Issues one column offset per clock for a 4- or 8-beat burst in sequential
// (nibble-wrapped) or interleaved order, with a final-beat flag and an error
// pulse for reserved length codes.
// Assumes the request fields are valid in the same cycle as start_i.
module burst_order_gen
    import burst_order_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [CODE_W-1:0] len_code_i,
    input  logic             order_i,
    output logic             beat_vld_o,
    output logic [COL_W-1:0] col_off_o,
    output logic             last_o,
    output logic             cfg_err_o
);
    logic              len_ok;
    logic              is8;
    logic              load;
    logic [BEAT_W-1:0] beat;
    logic [COL_W-1:0]  col_q;
    order_e            ord_q;

    burst_cfg_decode u_dec (
        .len_code_i (len_code_i),
        .len_ok_o   (len_ok),
        .is8_o      (is8)
    );

    burst_beat_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .len_ok_i (len_ok),
        .is8_i    (is8),
        .active_o (beat_vld_o),
        .beat_o   (beat),
        .last_o   (last_o),
        .load_o   (load),
        .err_o    (cfg_err_o)
    );

    // Purpose: hold the accepted start column and ordering for the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            ord_q <= ORD_SEQ;
        end else if (load) begin
            col_q <= start_col_i;
            ord_q <= order_e'(order_i);
        end
    end

    burst_offset_map u_map (
        .start_col_i (col_q),
        .beat_i      (beat),
        .order_i     (ord_q),
        .col_off_o   (col_off_o)
    );

    AST_FIRST_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat_vld_o) |-> $past(start_i)); // R6

    AST_MID_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && !last_o) |=> ($stable(col_q) && $stable(ord_q))); // R8

    AST_LAST_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> beat_vld_o); // R7
endmodule

// File: tb/burst_order_gen_bench.sv
module burst_order_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       order_i = 1'b0;
    logic       beat_vld_o;
    logic [2:0] col_off_o;
    logic       last_o;
    logic       cfg_err_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit model_on = 1'b0;

    // expected beat: offset and tag of the ordering requirement
    typedef struct { int off; string tag; } beat_t;
    beat_t q[$];
    bit err_exp = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    burst_order_gen u_burst_order_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .order_i(order_i), .beat_vld_o(beat_vld_o),
        .col_off_o(col_off_o), .last_o(last_o), .cfg_err_o(cfg_err_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Reference model: advances on each rising edge from the sampled inputs.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            q.delete();
            err_exp = 1'b0;
        end else if (model_on) begin
            bit accept;
            int n;
            accept = start_i && (q.size() <= 1);
            if (q.size() > 0) void'(q.pop_front());
            err_exp = 1'b0;
            if (accept) begin
                // R1: 010 -> 4, 011 -> 8, others reserved
                n = (len_code_i == 3'b010) ? 4 : (len_code_i == 3'b011) ? 8 : 0;
                if (n == 0) err_exp = 1'b1;
                for (int i = 0; i < n; i++) begin
                    beat_t b;
                    int s;
                    s = start_col_i;
                    if (order_i) begin
                        b.off = s ^ i;
                        b.tag = "R2 R5 interleaved";
                    end else begin
                        b.off = ((s & 4) ^ ((i >= 4) ? 4 : 0)) + ((s + i) % 4);
                        b.tag = (n == 4) ? "R2 R3 seq4" : "R2 R4 seq8";
                    end
                    q.push_back(b);
                end
            end
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (rst_n && model_on) begin
            check(beat_vld_o == (q.size() > 0), "R1 R6 R8 R9 beat_vld", beat_vld_o, q.size() > 0);
            check(last_o == (q.size() == 1), "R7 last", last_o, q.size() == 1);
            check(cfg_err_o == err_exp, "R10 cfg_err", cfg_err_o, err_exp);
            if (q.size() > 0 && beat_vld_o)
                check(col_off_o == q[0].off, q[0].tag, col_off_o, q[0].off);
        end
    end

    task automatic req(input bit [2:0] col, input bit [2:0] code, input bit ord);
        start_i = 1'b1; start_col_i = col; len_code_i = code; order_i = ord;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #400000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R11: outputs low during reset
        check(!beat_vld_o && !last_o && !cfg_err_o, "R11 reset outputs", {beat_vld_o, last_o, cfg_err_o}, 0);
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        check(!beat_vld_o && !last_o && !cfg_err_o, "R11 after reset", {beat_vld_o, last_o, cfg_err_o}, 0);
        model_on = 1'b1;

        // R3 R4 R5: every start column in every legal mode
        for (int c = 0; c < 8; c++) begin
            req(3'(c), 3'b010, 1'b0); idle(5);
            req(3'(c), 3'b011, 1'b0); idle(9);
            req(3'(c), 3'b010, 1'b1); idle(5);
            req(3'(c), 3'b011, 1'b1); idle(9);
        end

        // R10: reserved codes
        for (int k = 0; k < 8; k++) begin
            if (k != 2 && k != 3) begin
                req(3'd1, 3'(k), 1'b0); idle(2);
            end
        end

        // R8: starts in the middle of a burst with other fields
        req(3'd5, 3'b011, 1'b0);
        idle(2);
        req(3'd2, 3'b010, 1'b1);
        req(3'd0, 3'b001, 1'b0);
        idle(8);

        // R9: back-to-back on the final beat (start issued N clocks later)
        req(3'd6, 3'b010, 1'b0); idle(3);
        req(3'd3, 3'b011, 1'b1); idle(7);
        req(3'd5, 3'b011, 1'b0); idle(7);
        // reserved code on the final beat ends the burst with an error
        req(3'd1, 3'b111, 1'b0); idle(4);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule